// File: doc/BRIEF.md
# Vectored Interrupt Controller

The controller takes a set of level-sensitive interrupt request lines from peripherals and drives two interrupt outputs to a processor: a fast interrupt (`fiq_o`) and a normal interrupt (`irq_o`). Software programs it over a simple word-addressed register bus. For each source it sets an enable and a class bit that marks the source as fast. A normal-class source counts as vectored when an enabled slot names it; any other normal-class source counts as non-vectored. There are sixteen ordered vector slots. Each slot holds a source number, a slot enable and a handler address.

A fast handler reads a status word that shows which fast-class sources are requesting. A normal handler reads the vector register, which returns one of two things. If a vectored slot is active, it returns the handler address of the highest-priority active slot. Otherwise it returns a programmable default address that all non-vectored sources share. A second status word lists the pending normal-class sources. Reading the vector register freezes the returned address until software writes the vector register to signal end of service. Higher-priority slots can therefore pre-empt only at those points. A force register lets software raise any request line.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears every source enable, every class bit, the force word, the default address and all slots. Both outputs are 0 in the cycle after reset, and every register reads 0.
- R2: `fiq_o` is 1 one clock after any source is requesting, enabled and fast-class at a clock edge. The fast status word (word 0x03, bit n = source n) shows those sources without delay.
- R3: `irq_o` is 1 one clock after any source is requesting, enabled and normal-class at a clock edge. The normal status word (word 0x04, bit n = source n) shows those sources.
- R4: A slot (control word 0x10+k, bit 5 = slot enable, bits 4:0 = source number; handler word 0x20+k) takes part in arbitration only when three things hold: the slot is enabled, its source is enabled and requesting, and its source is not fast-class.
- R5: Reading the vector word (0x05) returns the handler address of the lowest-numbered active slot. Slot 0 is the highest priority.
- R6: With no active slot, the vector word returns the default address (word 0x06).
- R7: A read of the vector word captures the returned address. Later reads return the same value, even if a higher-priority slot becomes active, until a write to word 0x05 releases it.
- R8: The force word (0x02) is ORed with the request inputs before enable and class are applied.
- R9: A source whose enable bit (word 0x00) is clear has no effect on either output, either status word or the vector word.
- R10: Setting a source's class bit (word 0x01, 1 = fast) at run time moves the source from the normal outputs, status word and arbitration to the fast ones on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | NUM_SRC | Level-sensitive request lines |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the access |
| fiq_o | output | 1 | Registered fast interrupt |
| irq_o | output | 1 | Registered normal interrupt |

## Verification
Assertions check the following on every cycle:
- Each registered output follows its pending set.
- The arbitration winner is active, and no lower-numbered slot is active.
- The winner's source is never fast-class.
- A captured vector address stays stable until released.
- The outputs are quiet after reset.

Only the bench's scenarios can show the rest:
- That the address returned on a read matches the intended slot for each combination of slot enable, source enable and class.
- The fall-back to the default address.
- That a higher-priority request is held off across the capture-and-release sequence.
- That force, reclassification and disabled sources have the intended visible effects.

A behavioural model in the bench, compared on every clock under random traffic, covers these.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int DATA_W = 32;
    localparam int BUS_AW = 6;

    localparam logic [BUS_AW-1:0] REG_SRC_EN    = 6'h00;
    localparam logic [BUS_AW-1:0] REG_FAST      = 6'h01;
    localparam logic [BUS_AW-1:0] REG_FORCE     = 6'h02;
    localparam logic [BUS_AW-1:0] REG_FAST_STAT = 6'h03;
    localparam logic [BUS_AW-1:0] REG_NORM_STAT = 6'h04;
    localparam logic [BUS_AW-1:0] REG_VECTOR    = 6'h05;
    localparam logic [BUS_AW-1:0] REG_DEFAULT   = 6'h06;
    localparam int               REG_SLOT_CTL  = 'h10;
    localparam int               REG_SLOT_ADR  = 'h20;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] addr;
    } vec_lock_t;

    function automatic logic [BUS_AW-1:0] slot_reg(input int base, input int idx);
        return BUS_AW'(base + idx);
    endfunction

endpackage

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_SLOT = 16,
    parameter int SRC_W    = $clog2(NUM_SRC)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [NUM_SRC-1:0]  src_en,
    output logic [NUM_SRC-1:0]  fast_mask,
    output logic [NUM_SRC-1:0]  force_mask,
    output logic [DATA_W-1:0]   default_addr,
    output logic                slot_en   [NUM_SLOT],
    output logic [SRC_W-1:0]    slot_src  [NUM_SLOT],
    output logic [DATA_W-1:0]   slot_addr [NUM_SLOT],
    output logic [DATA_W-1:0]   cfg_rdata
);

    logic wr;
    assign wr = bus_sel && bus_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_en       <= '0;
            fast_mask    <= '0;
            force_mask   <= '0;
            default_addr <= '0;
        end else if (wr) begin
            case (bus_addr)
                REG_SRC_EN:  src_en       <= bus_wdata[NUM_SRC-1:0];
                REG_FAST:    fast_mask    <= bus_wdata[NUM_SRC-1:0];
                REG_FORCE:   force_mask   <= bus_wdata[NUM_SRC-1:0];
                REG_DEFAULT: default_addr <= bus_wdata;
                default: ;
            endcase
        end
    end

    for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_en[k]   <= 1'b0;
                slot_src[k]  <= '0;
                slot_addr[k] <= '0;
            end else if (wr) begin
                if (bus_addr == slot_reg(REG_SLOT_CTL, k)) begin
                    slot_en[k]  <= bus_wdata[SRC_W];
                    slot_src[k] <= bus_wdata[SRC_W-1:0];
                end
                if (bus_addr == slot_reg(REG_SLOT_ADR, k))
                    slot_addr[k] <= bus_wdata;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (bus_addr)
            REG_SRC_EN:  cfg_rdata = DATA_W'(src_en);
            REG_FAST:    cfg_rdata = DATA_W'(fast_mask);
            REG_FORCE:   cfg_rdata = DATA_W'(force_mask);
            REG_DEFAULT: cfg_rdata = default_addr;
            default: ;
        endcase
        for (int i = 0; i < NUM_SLOT; i++) begin
            if (bus_addr == slot_reg(REG_SLOT_CTL, i))
                cfg_rdata = DATA_W'({slot_en[i], slot_src[i]});
            if (bus_addr == slot_reg(REG_SLOT_ADR, i))
                cfg_rdata = slot_addr[i];
        end
    end

    // R1: the register set is empty in the cycle after reset
    assert_cfg_cleared_R1: assert property (@(posedge clk)
        rst |=> (src_en == '0) && (fast_mask == '0) && (force_mask == '0))
        else $error("config not cleared by reset");

endmodule

// File: rtl/vic_slot_arb.sv
module vic_slot_arb
    import vic_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_SLOT = 16,
    parameter int SRC_W    = $clog2(NUM_SRC),
    parameter int IDX_W    = $clog2(NUM_SLOT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_live,
    input  logic                slot_en   [NUM_SLOT],
    input  logic [SRC_W-1:0]    slot_src  [NUM_SLOT],
    input  logic [DATA_W-1:0]   slot_addr [NUM_SLOT],
    output logic                win_vld,
    output logic [IDX_W-1:0]    win_idx,
    output logic [DATA_W-1:0]   win_addr
);

    logic [NUM_SLOT-1:0] act;
    logic [NUM_SLOT-1:0] above_mask;

    for (genvar k = 0; k < NUM_SLOT; k++) begin : g_act
        assign act[k] = slot_en[k] && src_live[slot_src[k]];
    end

    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        for (int k = NUM_SLOT - 1; k >= 0; k--) begin
            if (act[k]) begin
                win_vld = 1'b1;
                win_idx = IDX_W'(k);
            end
        end
    end

    assign win_addr   = slot_addr[win_idx];
    assign above_mask = (NUM_SLOT'(1) << win_idx) - NUM_SLOT'(1);

    // R5: the chosen slot is itself active
    assert_winner_active_R5: assert property (@(posedge clk) disable iff (rst)
        win_vld |-> act[win_idx])
        else $error("winning slot not active");

    // R5: no slot with a smaller number is active
    assert_no_better_slot_R5: assert property (@(posedge clk) disable iff (rst)
        win_vld |-> ((act & above_mask) == '0))
        else $error("higher priority slot skipped");

    // R6: no winner only when nothing is active
    assert_idle_only_when_none_R6: assert property (@(posedge clk) disable iff (rst)
        !win_vld |-> (act == '0))
        else $error("active slot without winner");

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_SLOT = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  irq_src_i,
    input  logic                bus_sel_i,
    input  logic                bus_we_i,
    input  logic [BUS_AW-1:0]   bus_addr_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    output logic                fiq_o,
    output logic                irq_o
);

    localparam int SRC_W = $clog2(NUM_SRC);
    localparam int IDX_W = $clog2(NUM_SLOT);

    logic [NUM_SRC-1:0] src_en, fast_mask, force_mask;
    logic [DATA_W-1:0]  default_addr, cfg_rdata;
    logic               slot_en   [NUM_SLOT];
    logic [SRC_W-1:0]   slot_src  [NUM_SLOT];
    logic [DATA_W-1:0]  slot_addr [NUM_SLOT];

    vic_regs #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .SRC_W(SRC_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .bus_sel      (bus_sel_i),
        .bus_we       (bus_we_i),
        .bus_addr     (bus_addr_i),
        .bus_wdata    (bus_wdata_i),
        .src_en       (src_en),
        .fast_mask    (fast_mask),
        .force_mask   (force_mask),
        .default_addr (default_addr),
        .slot_en      (slot_en),
        .slot_src     (slot_src),
        .slot_addr    (slot_addr),
        .cfg_rdata    (cfg_rdata)
    );

    logic [NUM_SRC-1:0] req_eff, fast_pend, norm_pend;
    assign req_eff   = irq_src_i | force_mask;
    assign fast_pend = req_eff & src_en & fast_mask;
    assign norm_pend = req_eff & src_en & ~fast_mask;

    logic              win_vld;
    logic [IDX_W-1:0]  win_idx;
    logic [DATA_W-1:0] win_addr;

    vic_slot_arb #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .SRC_W(SRC_W), .IDX_W(IDX_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .src_live  (norm_pend),
        .slot_en   (slot_en),
        .slot_src  (slot_src),
        .slot_addr (slot_addr),
        .win_vld   (win_vld),
        .win_idx   (win_idx),
        .win_addr  (win_addr)
    );

    logic              vec_rd, vec_wr;
    logic [DATA_W-1:0] vec_live, vec_value;
    vec_lock_t         lock_q;

    assign vec_rd    = bus_sel_i && !bus_we_i && (bus_addr_i == REG_VECTOR);
    assign vec_wr    = bus_sel_i &&  bus_we_i && (bus_addr_i == REG_VECTOR);
    assign vec_live  = win_vld ? win_addr : default_addr;
    assign vec_value = lock_q.vld ? lock_q.addr : vec_live;

    always_ff @(posedge clk) begin
        if (rst)
            lock_q <= '0;
        else if (vec_wr)
            lock_q.vld <= 1'b0;
        else if (vec_rd && !lock_q.vld)
            lock_q <= '{vld: 1'b1, addr: vec_live};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fiq_o <= 1'b0;
            irq_o <= 1'b0;
        end else begin
            fiq_o <= |fast_pend;
            irq_o <= |norm_pend;
        end
    end

    always_comb begin
        case (bus_addr_i)
            REG_FAST_STAT: bus_rdata_o = DATA_W'(fast_pend);
            REG_NORM_STAT: bus_rdata_o = DATA_W'(norm_pend);
            REG_VECTOR:    bus_rdata_o = vec_value;
            default:       bus_rdata_o = cfg_rdata;
        endcase
    end

    // R1: outputs quiet right after reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        rst |=> !fiq_o && !irq_o)
        else $error("outputs active after reset");

    // R2: a pending fast source raises fiq_o next cycle
    assert_fiq_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (|fast_pend) |=> fiq_o)
        else $error("fiq_o missed a pending fast source");

    // R3: irq_o low next cycle when no normal source is pending
    assert_irq_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !(|norm_pend) |=> !irq_o)
        else $error("irq_o set with nothing pending");

    // R4: the winning slot never points at a fast-class source
    assert_winner_not_fast_R4: assert property (@(posedge clk) disable iff (rst)
        win_vld |-> !fast_mask[slot_src[win_idx]])
        else $error("fast source won vector arbitration");

    // R7: a captured address holds until the end-of-service write
    assert_lock_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (lock_q.vld && !vec_wr) |=> (lock_q.vld && $stable(lock_q.addr)))
        else $error("captured vector changed before release");

endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_src = '0;
    logic        sel = 1'b0, we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fiq, irq;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst(rst), .irq_src_i(irq_src),
        .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // behavioural reference state
    logic [31:0] m_en, m_fast, m_force, m_def;
    bit          m_sen   [16];
    int          m_ssrc  [16];
    logic [31:0] m_saddr [16];
    bit          m_lock;
    logic [31:0] m_lock_a;
    bit          m_fiq, m_irq;

    function automatic logic [31:0] m_vec_live();
        logic [31:0] live = (irq_src | m_force) & m_en & ~m_fast;
        for (int k = 0; k < 16; k++)
            if (m_sen[k] && live[m_ssrc[k]]) return m_saddr[k];
        return m_def;
    endfunction

    function automatic logic [31:0] m_read(input int a);
        logic [31:0] eff = irq_src | m_force;
        if (a == 0) return m_en;
        if (a == 1) return m_fast;
        if (a == 2) return m_force;
        if (a == 3) return eff & m_en & m_fast;
        if (a == 4) return eff & m_en & ~m_fast;
        if (a == 5) return m_lock ? m_lock_a : m_vec_live();
        if (a == 6) return m_def;
        if (a >= 'h10 && a < 'h20) return (m_sen[a-'h10] ? 32'h20 : 32'h0) | 32'(m_ssrc[a-'h10]);
        if (a >= 'h20 && a < 'h30) return m_saddr[a-'h20];
        return 32'h0;
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R9";
            1: return "R10";
            2: return "R8";
            3: return "R2";
            4: return "R3";
            5: return "R5 R7";
            6: return "R6";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_en = '0; m_fast = '0; m_force = '0; m_def = '0;
            m_lock = 0; m_lock_a = '0; m_fiq = 0; m_irq = 0;
            for (int k = 0; k < 16; k++) begin m_sen[k] = 0; m_ssrc[k] = 0; m_saddr[k] = '0; end
        end else begin
            m_fiq = |((irq_src | m_force) & m_en & m_fast);
            m_irq = |((irq_src | m_force) & m_en & ~m_fast);
            if (sel && addr == 5) begin
                if (we) m_lock = 0;
                else if (!m_lock) begin m_lock = 1; m_lock_a = m_vec_live(); end
            end
            if (sel && we) begin
                case (int'(addr))
                    0: m_en = wdata;
                    1: m_fast = wdata;
                    2: m_force = wdata;
                    6: m_def = wdata;
                    default: begin
                        if (addr >= 'h10 && addr < 'h20) begin
                            m_sen[addr-'h10] = wdata[5];
                            m_ssrc[addr-'h10] = int'(wdata[4:0]);
                        end else if (addr >= 'h20 && addr < 'h30)
                            m_saddr[addr-'h20] = wdata;
                    end
                endcase
            end
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 fiq", 32'(fiq), 32'(m_fiq));
            chk("R3 irq", 32'(irq), 32'(m_irq));
            if (sel && !we) chk(tag_of(int'(addr)), rdata, m_read(int'(addr)));
        end
    end

    task automatic step(); @(posedge clk); #1; endtask

    task automatic wr(input int a, input logic [31:0] d);
        sel = 1; we = 1; addr = 6'(a); wdata = d;
        step();
        sel = 0; we = 0;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        sel = 1; we = 0; addr = 6'(a);
        @(negedge clk);
        chk(tag, rdata, exp);
        step();
        sel = 0;
    endtask

    task automatic chk_out(input string tag, input bit ef, input bit ei);
        @(negedge clk);
        chk({tag, " fiq_o"}, 32'(fiq), 32'(ef));
        chk({tag, " irq_o"}, 32'(irq), 32'(ei));
        step();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1: reset state
        chk_out("R1", 0, 0);
        rd(0, 0, "R1"); rd(1, 0, "R1"); rd('h13, 0, "R1"); rd('h2F, 0, "R1");
        rd(5, 0, "R1"); wr(5, 0);

        // R3 / R6: one enabled non-vectored source
        wr(6, 32'h1000); wr(0, 32'h8);
        irq_src = 32'h8; step();
        chk_out("R3", 0, 1);
        rd(4, 32'h8, "R3"); rd(3, 0, "R2");
        rd(5, 32'h1000, "R6"); wr(5, 0);

        // R10 / R2: reclassify to fast
        wr(1, 32'h8); step();
        chk_out("R10", 1, 0);
        rd(3, 32'h8, "R2"); rd(4, 0, "R10");

        // R9: disabled source 7
        irq_src = 32'h88; step();
        chk_out("R9", 1, 0);
        rd(4, 0, "R9"); rd(3, 32'h8, "R9");
        wr(1, 0); irq_src = 0;

        // R5 / R4: slots 2 (src 5) and 9 (src 6)
        wr('h12, 32'h25); wr('h22, 32'h200);
        wr('h19, 32'h26); wr('h29, 32'h900);
        wr(0, 32'h68);
        irq_src = 32'h40; step();
        rd(5, 32'h900, "R5"); wr(5, 0);
        irq_src = 32'h60; step();
        rd(5, 32'h200, "R5"); wr(5, 0);
        wr('h12, 32'h05);
        rd(5, 32'h900, "R4 slot disabled"); wr(5, 0);
        wr('h12, 32'h25); wr(1, 32'h20);
        rd(5, 32'h900, "R4 fast source"); wr(5, 0);
        chk_out("R4", 1, 1);
        wr(1, 0); wr(0, 32'h48);
        rd(5, 32'h900, "R4 source disabled"); wr(5, 0);
        wr(0, 32'h60);

        // R7: capture and release
        irq_src = 32'h40; step();
        rd(5, 32'h900, "R7");
        irq_src = 32'h60; step(); step();
        rd(5, 32'h900, "R7 held");
        wr(5, 0);
        rd(5, 32'h200, "R7 released"); wr(5, 0);

        // R8: force word
        irq_src = 0; wr(0, 32'h400); wr(2, 32'h400); step();
        chk_out("R8", 0, 1);
        rd(4, 32'h400, "R8");
        wr(2, 0); step();
        chk_out("R8 cleared", 0, 0);

        // random traffic against the reference model
        for (int i = 0; i < 4000; i++) begin
            int op = $urandom % 10;
            if ($urandom % 4 == 0) irq_src = $urandom;
            sel = 0; we = 0;
            if (op < 3) begin
                sel = 1; we = 0;
                case ($urandom % 6)
                    0: addr = 6'($urandom % 7);
                    1: addr = 6'(5);
                    2: addr = 6'('h10 + $urandom % 16);
                    3: addr = 6'('h20 + $urandom % 16);
                    4: addr = 6'($urandom);
                    default: addr = 6'(3 + $urandom % 2);
                endcase
            end else if (op == 3) begin
                sel = 1; we = 1; addr = 6'(5); wdata = $urandom;
            end else if (op == 4) begin
                sel = 1; we = 1; wdata = $urandom;
                case ($urandom % 5)
                    0: addr = 6'($urandom % 7);
                    1: begin addr = 6'('h10 + $urandom % 16); wdata = 32'($urandom % 64); end
                    2: addr = 6'('h20 + $urandom % 16);
                    3: begin addr = 6'(2); wdata = $urandom & $urandom & $urandom; end
                    default: addr = 6'($urandom);
                endcase
            end
            step();
        end
        sel = 0; we = 0;
        step();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule